// File: doc/BRIEF.md
# Latency-Ring Issue Stage

This block is the issue stage of a single-issue microcode engine that has no interlocks. Each cycle that `issue_valid` is high it takes one 25-bit instruction word, reads two source registers from a 128-entry general-purpose bank, and computes a result. Simple integer and bit-level operations are computed inside the block. Operations that need a floating-point datapath are handed to external units: the block drives the opcode and both operands out, and takes the result back on `ext_result` in the same cycle.

Results are not written straight to the instruction's own destination. Each result is placed into a circular writeback ring of 7 slots, at a position set by the opcode's fixed latency. In every issuing cycle, the slot at the head of the ring is written into the register named by the destination field of the instruction issued in that cycle. That slot is then cleared and the head moves on. The compiler therefore schedules every writeback statically, by placing a destination field exactly as many instructions after the producing instruction as its latency. The emit opcode hands two registers to an output stream and ends the current program.

A loader port fills registers before a program runs, for example with the mesh position and constants. The program counter goes out to an external instruction store.

Top module: `lsi_issue_stage`

## Requirements
- R1: The instruction word is split as source A = bits [24:18], source B = bits [17:11], opcode = bits [10:7] and destination = bits [6:0]. While an instruction is presented, `ext_op` carries its opcode, and `ext_a` and `ext_b` carry the current contents of the registers named by source A and source B.
- R2: An instruction that is issued at issue step t and whose opcode is not 0 has its result delivered on the writeback port at issue step t+L. The latency L is 5 for opcodes 1 and 2, 7 for opcode 3, 3 for opcode 6, 4 for opcodes 8 and 9, and 2 for opcodes 4, 5 and 10 to 15. Opcode 0 schedules nothing.
- R3: In each issuing cycle with a non-emit opcode and a nonzero destination, `wb_en` is 1, `wb_reg` is the destination, and `wb_data` is the value at the head of the ring, and that register takes this value. With destination 0, `wb_en` stays 0 and no register changes.
- R4: A ring slot is cleared after it is delivered. A step for which no result was scheduled delivers zero, and no value is delivered twice.
- R5: Opcode 7 (emit) raises `vec_valid` and `end_of_prog`, drives `vec_a` and `vec_b` with the registers named by source A and source B, performs no writeback, and leaves the ring untouched. The program counter then returns to 0.
- R6: Each issued non-emit instruction increments `pc` by one. While `issue_valid` is low, `pc`, the ring and the registers are frozen, apart from loader writes.
- R7: Opcode 10 gives 0x3F800000 if A is greater than B, and opcode 11 gives 0x3F800000 if A equals B; otherwise each gives 0. Both compare the operands as sign-magnitude values, and +0 equals -0.
- R8: Opcode 13 yields A when register 2 is nonzero and B when register 2 is zero.
- R9: Opcode 14 yields A with bit 31 inverted when B is negative (bit 31 set and bits [30:0] nonzero), and yields A unchanged otherwise.
- R10: Opcode 4 yields A with bit 31 cleared, opcode 12 yields A unchanged, and opcode 15 yields 0x5F3759DF minus (A logically shifted right by one).
- R11: Opcodes 1, 2, 3, 5, 6, 8 and 9 take their result from `ext_result`, sampled in the cycle of issue.
- R12: `load_en` writes `load_data` into register `load_addr` at the clock edge. If a writeback targets the same register in the same cycle, the writeback wins.
- R13: After reset, `pc` is 0, all registers are 0 and every ring slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_word | input | 25 | Instruction word |
| load_en | input | 1 | Loader write strobe |
| load_addr | input | 7 | Loader target register |
| load_data | input | 32 | Loader write value |
| ext_op | output | 4 | Opcode offered to the external units |
| ext_a | output | 32 | Source A operand value |
| ext_b | output | 32 | Source B operand value |
| ext_result | input | 32 | Result returned by the external units |
| wb_en | output | 1 | A register writeback occurs this cycle |
| wb_reg | output | 7 | Writeback target register |
| wb_data | output | 32 | Value delivered from the ring head |
| vec_valid | output | 1 | Emit instruction this cycle |
| vec_a | output | 32 | First emitted value |
| vec_b | output | 32 | Second emitted value |
| end_of_prog | output | 1 | Current program ends this cycle |
| pc | output | 11 | Program counter to the instruction store |

## Verification
The hardest state to reach is one where the ring holds several results of different latencies at once, and an emit, a stall or a loader write to the same register lands between their scheduling and their delivery. Only long mixed streams create overlaps like that. The stimulus is a long deterministic pseudo-random stream over all sixteen opcodes. It adds random stalls, loader writes and register-2 flag changes, and draws operands from a pool that includes both zeros and ±1.0. A reference model keeps an absolute-step table of scheduled results, so it shares no structure with the ring. Directed sequences pin the seven-cycle multiply delivery, the signed-zero comparisons and the case where a loader write and a writeback target the same register.

// File: rtl/lsi_pkg.sv
package lsi_pkg;

    localparam int DATA_W  = 32;
    localparam int REG_AW  = 7;
    localparam int NREG    = 1 << REG_AW;
    localparam int OP_W    = 4;
    localparam int WORD_W  = 3 * REG_AW + OP_W;
    localparam int RING_N  = 7;
    localparam int LAT_W   = $clog2(RING_N + 1);
    localparam int PC_W    = 11;

    localparam logic [DATA_W-1:0] FP_ONE    = 32'h3F80_0000;
    localparam logic [DATA_W-1:0] RSQ_SEED  = 32'h5F37_59DF;
    localparam logic [DATA_W-1:0] SIGN_MASK = 32'h8000_0000;

    typedef enum logic [OP_W-1:0] {
        OPC_NOP  = 4'd0,
        OPC_ADD  = 4'd1,
        OPC_SUB  = 4'd2,
        OPC_MUL  = 4'd3,
        OPC_ABS  = 4'd4,
        OPC_FTOI = 4'd5,
        OPC_ITOF = 4'd6,
        OPC_EMIT = 4'd7,
        OPC_SIN  = 4'd8,
        OPC_COS  = 4'd9,
        OPC_GT   = 4'd10,
        OPC_EQ   = 4'd11,
        OPC_MOV  = 4'd12,
        OPC_SEL  = 4'd13,
        OPC_SGN  = 4'd14,
        OPC_RSQ  = 4'd15
    } opc_e;

    // Field order is fixed by the instruction encoding (MSB first).
    typedef struct packed {
        logic [REG_AW-1:0] src_a;
        logic [REG_AW-1:0] src_b;
        opc_e              op;
        logic [REG_AW-1:0] dst;
    } insn_t;

    function automatic logic [LAT_W-1:0] op_latency(input opc_e op);
        case (op)
            OPC_ADD, OPC_SUB: return LAT_W'(5);
            OPC_MUL:          return LAT_W'(7);
            OPC_ITOF:         return LAT_W'(3);
            OPC_SIN, OPC_COS: return LAT_W'(4);
            OPC_EMIT:         return LAT_W'(0);
            default:          return LAT_W'(2);
        endcase
    endfunction

    function automatic logic uses_ext_unit(input opc_e op);
        case (op)
            OPC_ADD, OPC_SUB, OPC_MUL, OPC_FTOI,
            OPC_ITOF, OPC_SIN, OPC_COS: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lsi_decode.sv
module lsi_decode
    import lsi_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output insn_t             fields,
    output logic [LAT_W-1:0]  latency,
    output logic              emit,
    output logic              advance,
    output logic              schedule
);

    always_comb begin
        fields   = insn_t'(word);
        latency  = op_latency(fields.op);
        emit     = valid && (fields.op == OPC_EMIT);
        advance  = valid && (fields.op != OPC_EMIT);
        schedule = advance && (fields.op != OPC_NOP);
    end

endmodule

// File: rtl/lsi_alu.sv
module lsi_alu
    import lsi_pkg::*;
(
    input  opc_e              op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              flag_nz,
    input  logic [DATA_W-1:0] ext_result,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] key_a, key_b;
    logic              b_negative;

    // Monotonic unsigned key for sign-magnitude values; both zeros map alike.
    function automatic logic [DATA_W-1:0] order_key(input logic [DATA_W-1:0] v);
        if (v[DATA_W-2:0] == '0)
            return SIGN_MASK;
        else if (v[DATA_W-1])
            return ~v;
        else
            return v | SIGN_MASK;
    endfunction

    always_comb begin
        key_a      = order_key(opa);
        key_b      = order_key(opb);
        b_negative = opb[DATA_W-1] && (opb[DATA_W-2:0] != '0);
        result     = '0;
        if (uses_ext_unit(op)) begin
            result = ext_result;
        end else begin
            case (op)
                OPC_ABS: result = opa & ~SIGN_MASK;
                OPC_GT:  result = (key_a > key_b) ? FP_ONE : '0;
                OPC_EQ:  result = (key_a == key_b) ? FP_ONE : '0;
                OPC_MOV: result = opa;
                OPC_SEL: result = flag_nz ? opa : opb;
                OPC_SGN: result = b_negative ? (opa ^ SIGN_MASK) : opa;
                OPC_RSQ: result = RSQ_SEED - (opa >> 1);
                default: result = '0;
            endcase
        end
    end

endmodule

// File: rtl/lsi_ring.sv
module lsi_ring
    import lsi_pkg::*;
#(
    parameter int DEPTH = RING_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              schedule,
    input  logic [LAT_W-1:0]  latency,
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] head_data
);

    localparam int HEAD_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] slot;
        logic [HEAD_W-1:0]            head;
    } ring_t;

    ring_t             s_d, s_q;
    logic [HEAD_W-1:0] next_head_d;
    logic [HEAD_W-1:0] ins_idx_d;
    int                sum_d;

    assign head_data = s_q.slot[s_q.head];

    always_comb begin
        s_d         = s_q;
        next_head_d = (int'(s_q.head) == DEPTH - 1) ? '0 : s_q.head + 1'b1;
        sum_d       = int'(next_head_d) + int'(latency) - 1;
        if (sum_d >= DEPTH)
            sum_d = sum_d - DEPTH;
        ins_idx_d   = HEAD_W'(sum_d);
        if (advance) begin
            s_d.slot[s_q.head] = '0;
            s_d.head           = next_head_d;
            if (schedule)
                s_d.slot[ins_idx_d] = value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    // R2: a scheduled latency must fit the ring
    a_r2_latency_fits: assert property (@(posedge clk) disable iff (!rst_n)
        schedule |-> (latency >= 1 && int'(latency) <= DEPTH));

    // R4: the drained slot is empty afterwards unless refilled by a full-depth result
    a_r4_slot_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !(schedule && int'(latency) == DEPTH))
        |=> s_q.slot[$past(s_q.head)] == '0);

    // R6: no issue means the ring is frozen
    a_r6_ring_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> ($stable(s_q.head) && $stable(s_q.slot)));

endmodule

// File: rtl/lsi_gpr.sv
module lsi_gpr
    import lsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [REG_AW-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              wb_en,
    input  logic [REG_AW-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [REG_AW-1:0] rd_a_addr,
    input  logic [REG_AW-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    output logic              flag_nz
);

    localparam logic [REG_AW-1:0] FLAG_REG = REG_AW'(2);

    logic [DATA_W-1:0] rf_d [NREG];
    logic [DATA_W-1:0] rf_q [NREG];

    assign rd_a    = rf_q[rd_a_addr];
    assign rd_b    = rf_q[rd_b_addr];
    assign flag_nz = (rf_q[FLAG_REG] != '0);

    always_comb begin
        rf_d = rf_q;
        if (load_en)
            rf_d[load_addr] = load_data;
        if (wb_en)
            rf_d[wb_addr] = wb_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                rf_q[i] <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    // R3: register 0 is never a writeback target
    a_r3_null_sink: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_addr != '0);

    // R12: a writeback overrides a same-cycle loader write
    a_r12_wb_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && load_en && load_addr == wb_addr) |=> rf_q[$past(wb_addr)] == $past(wb_data));

endmodule

// File: rtl/lsi_issue_stage.sv
module lsi_issue_stage
    import lsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [24:0]       issue_word,
    input  logic              load_en,
    input  logic [6:0]        load_addr,
    input  logic [31:0]       load_data,
    output logic [3:0]        ext_op,
    output logic [31:0]       ext_a,
    output logic [31:0]       ext_b,
    input  logic [31:0]       ext_result,
    output logic              wb_en,
    output logic [6:0]        wb_reg,
    output logic [31:0]       wb_data,
    output logic              vec_valid,
    output logic [31:0]       vec_a,
    output logic [31:0]       vec_b,
    output logic              end_of_prog,
    output logic [10:0]       pc
);

    insn_t             fields;
    logic [LAT_W-1:0]  latency;
    logic              emit, advance, schedule;
    logic [DATA_W-1:0] opa, opb, alu_res, head_val;
    logic              flag_nz;
    logic [PC_W-1:0]   pc_d, pc_q;

    lsi_decode u_decode (
        .valid    (issue_valid),
        .word     (issue_word),
        .fields   (fields),
        .latency  (latency),
        .emit     (emit),
        .advance  (advance),
        .schedule (schedule)
    );

    lsi_gpr u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .wb_en     (wb_en),
        .wb_addr   (wb_reg),
        .wb_data   (wb_data),
        .rd_a_addr (fields.src_a),
        .rd_b_addr (fields.src_b),
        .rd_a      (opa),
        .rd_b      (opb),
        .flag_nz   (flag_nz)
    );

    lsi_alu u_alu (
        .op         (fields.op),
        .opa        (opa),
        .opb        (opb),
        .flag_nz    (flag_nz),
        .ext_result (ext_result),
        .result     (alu_res)
    );

    lsi_ring #(.DEPTH(RING_N)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .schedule  (schedule),
        .latency   (latency),
        .value     (alu_res),
        .head_data (head_val)
    );

    always_comb begin
        ext_op      = fields.op;
        ext_a       = opa;
        ext_b       = opb;
        wb_en       = advance && (fields.dst != '0);
        wb_reg      = fields.dst;
        wb_data     = head_val;
        vec_valid   = emit;
        vec_a       = opa;
        vec_b       = opb;
        end_of_prog = emit;
        pc          = pc_q;
        pc_d        = pc_q;
        if (emit)
            pc_d = '0;
        else if (advance)
            pc_d = pc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else
            pc_q <= pc_d;
    end

    // R6: one step per issued instruction
    a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> pc_q == $past(pc_q) + 1'b1);

    // R6: a stall holds the program counter
    a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> $stable(pc_q));

    // R5: emit restarts the program
    a_r5_pc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> pc_q == '0);

    // R5: emit never writes back
    a_r5_no_wb_on_emit: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !wb_en);

    // R7: comparisons only produce the two legal codes
    a_r7_cmp_code: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && (fields.op == OPC_GT || fields.op == OPC_EQ))
        |-> (alu_res == '0 || alu_res == FP_ONE));

endmodule

// File: tb/lsi_issue_stage_bench.sv
module lsi_issue_stage_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [24:0] issue_word = '0;
    logic        load_en = 1'b0;
    logic [6:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [3:0]  ext_op;
    logic [31:0] ext_a, ext_b, ext_result;
    logic        wb_en, vec_valid, end_of_prog;
    logic [6:0]  wb_reg;
    logic [31:0] wb_data, vec_a, vec_b;
    logic [10:0] pc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    // stand-in for the external floating-point units
    function automatic logic [31:0] ext_fn(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        return (a * 32'd3) ^ {b[15:0], b[31:16]} ^ {28'd0, op};
    endfunction

    assign ext_result = ext_fn(ext_op, ext_a, ext_b);

    lsi_issue_stage u_lsi_issue_stage (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_word(issue_word),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .ext_op(ext_op), .ext_a(ext_a), .ext_b(ext_b), .ext_result(ext_result),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
        .vec_valid(vec_valid), .vec_a(vec_a), .vec_b(vec_b),
        .end_of_prog(end_of_prog), .pc(pc)
    );

    // reference model: absolute-step table of pending results
    logic [31:0] m_rf [128];
    logic [31:0] m_pend [16];
    string       m_ptag [16];
    int          step = 0;
    int          m_pc = 0;
    logic [31:0] lcg = 32'h1234_5678;

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    function automatic int lat_of(input int op);
        case (op)
            1, 2:    return 5;
            3:       return 7;
            6:       return 3;
            8, 9:    return 4;
            default: return 2;
        endcase
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            1, 2, 3, 5, 6, 8, 9: return "R11";
            10, 11:              return "R7";
            13:                  return "R8";
            14:                  return "R9";
            default:             return "R10";
        endcase
    endfunction

    function automatic longint sval(input logic [31:0] x);
        return x[31] ? -longint'(x[30:0]) : longint'(x[30:0]);
    endfunction

    function automatic logic [31:0] model_res(input int op, input logic [31:0] a, input logic [31:0] b, input logic [31:0] f);
        case (op)
            1, 2, 3, 5, 6, 8, 9: return ext_fn(4'(op), a, b);
            4:  return {1'b0, a[30:0]};
            10: return (sval(a) > sval(b)) ? 32'h3F80_0000 : 32'h0;
            11: return (sval(a) == sval(b)) ? 32'h3F80_0000 : 32'h0;
            12: return a;
            13: return (f != 0) ? a : b;
            14: return (b[31] && b[30:0] != 0) ? {~a[31], a[30:0]} : a;
            15: return 32'h5F37_59DF - {1'b0, a[31:1]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [24:0] mk(input int sa, input int sb, input int op, input int dst);
        return {7'(sa), 7'(sb), 4'(op), 7'(dst)};
    endfunction

    task automatic do_idle(input bit ld, input int la, input logic [31:0] ld_val);
        @(negedge clk);
        issue_valid = 1'b0;
        load_en     = ld;
        load_addr   = 7'(la);
        load_data   = ld_val;
        #1;
        check(wb_en == 1'b0 && vec_valid == 1'b0, "R6", {31'd0, wb_en}, 32'd0);
        check(pc == 11'(m_pc), "R6", {21'd0, pc}, 32'(m_pc));
        if (ld) m_rf[la] = ld_val;
    endtask

    task automatic do_issue(input logic [24:0] w, input bit ld, input int la,
                            input logic [31:0] ld_val, input string tag_over);
        int sa, sb, op, dst, slot;
        logic [31:0] a, b, r, head;
        string t;
        @(negedge clk);
        issue_valid = 1'b1;
        issue_word  = w;
        load_en     = ld;
        load_addr   = 7'(la);
        load_data   = ld_val;
        #1;
        sa = int'(w[24:18]); sb = int'(w[17:11]); op = int'(w[10:7]); dst = int'(w[6:0]);
        a = m_rf[sa]; b = m_rf[sb];
        check(pc == 11'(m_pc), "R6", {21'd0, pc}, 32'(m_pc));
        check(ext_op == 4'(op) && ext_a == a && ext_b == b, "R1", ext_a, a);
        if (op == 7) begin
            check(vec_valid && end_of_prog, "R5", {31'd0, vec_valid}, 32'd1);
            check(vec_a == a && vec_b == b, "R5", vec_b, b);
            check(!wb_en, "R5", {31'd0, wb_en}, 32'd0);
            if (ld) m_rf[la] = ld_val;
            m_pc = 0;
        end else begin
            slot = step % 16;
            head = m_pend[slot];
            t = (tag_over != "") ? tag_over : m_ptag[slot];
            check(!vec_valid, "R5", {31'd0, vec_valid}, 32'd0);
            if (dst != 0) begin
                check(wb_en && wb_reg == 7'(dst), "R3", {25'd0, wb_reg}, 32'(dst));
                check(wb_data == head, t, wb_data, head);
            end else begin
                check(!wb_en, "R3", {31'd0, wb_en}, 32'd0);
            end
            r = model_res(op, a, b, m_rf[2]);
            if (ld) m_rf[la] = ld_val;
            if (dst != 0) m_rf[dst] = head;
            m_pend[slot] = 32'd0;
            m_ptag[slot] = "R4";
            if (op != 0) begin
                m_pend[(step + lat_of(op)) % 16] = r;
                m_ptag[(step + lat_of(op)) % 16] = tag_of(op);
            end
            step++;
            m_pc = (m_pc + 1) % 2048;
        end
    endtask

    initial begin
        logic [31:0] pool [8];
        for (int i = 0; i < 128; i++) m_rf[i] = 32'd0;
        for (int i = 0; i < 16; i++) begin m_pend[i] = 32'd0; m_ptag[i] = "R4"; end
        pool[0] = 32'h0000_0000; pool[1] = 32'h8000_0000;
        pool[2] = 32'h3F80_0000; pool[3] = 32'hBF80_0000;
        pool[4] = 32'h4049_0FDB; pool[5] = 32'hC000_0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(pc == 11'd0, "R13", {21'd0, pc}, 32'd0);
        check(!wb_en && !vec_valid, "R13", {31'd0, wb_en}, 32'd0);
        // empty ring delivers zero on every step after reset
        for (int k = 0; k < 8; k++) do_issue(mk(0, 0, 0, 9 + k), 1'b0, 0, 32'd0, "R13");

        // fill the bank through the loader
        for (int i = 1; i < 128; i++) begin
            lcg = nxt(lcg);
            pool[6] = lcg; pool[7] = {lcg[15:0], lcg[31:16]} ^ 32'h00FF_00FF;
            do_idle(1'b1, i, pool[lcg[30:28]]);
        end

        // R2: a multiply lands exactly seven steps later
        do_issue(mk(4, 5, 3, 0), 1'b0, 0, 32'd0, "R2");
        for (int k = 0; k < 6; k++) do_issue(mk(0, 0, 0, 20), 1'b0, 0, 32'd0, "R2");
        do_issue(mk(0, 0, 0, 21), 1'b0, 0, 32'd0, "R2");
        do_issue(mk(21, 0, 12, 0), 1'b0, 0, 32'd0, "R2");
        do_issue(mk(0, 0, 0, 0), 1'b0, 0, 32'd0, "R2");
        do_issue(mk(0, 0, 0, 22), 1'b0, 0, 32'd0, "R2");

        // R7: signed zeros compare equal, neither is above the other
        do_idle(1'b1, 40, 32'h8000_0000);
        do_idle(1'b1, 41, 32'h0000_0000);
        do_issue(mk(40, 41, 11, 0), 1'b0, 0, 32'd0, "R7");
        do_issue(mk(40, 41, 10, 0), 1'b0, 0, 32'd0, "R7");
        do_issue(mk(41, 40, 10, 42), 1'b0, 0, 32'd0, "R7");
        do_issue(mk(0, 0, 0, 43), 1'b0, 0, 32'd0, "R7");
        do_issue(mk(0, 0, 0, 44), 1'b0, 0, 32'd0, "R7");

        // R12: writeback and loader hit the same register in one cycle
        do_issue(mk(4, 0, 12, 0), 1'b0, 0, 32'd0, "R12");
        do_issue(mk(0, 0, 0, 0), 1'b0, 0, 32'd0, "R12");
        do_issue(mk(0, 0, 0, 31), 1'b1, 31, 32'hDEAD_BEEF, "R12");
        do_issue(mk(31, 0, 12, 0), 1'b0, 0, 32'd0, "R12");
        do_issue(mk(0, 0, 0, 0), 1'b0, 0, 32'd0, "R12");
        do_issue(mk(0, 0, 0, 32), 1'b0, 0, 32'd0, "R12");

        // long mixed stream: every opcode, stalls, emits, loads, flag toggles
        for (int n = 0; n < 6000; n++) begin
            int op, dst, la;
            logic [24:0] w;
            lcg = nxt(lcg);
            op  = int'(lcg[27:24]);
            if (lcg[31:29] == 3'd0) op = 7;
            dst = (lcg[23:22] == 2'd0) ? 0 : int'(lcg[6:0]);
            w   = {lcg[21:15], lcg[14:8], 4'(op), 7'(dst)};
            la  = lcg[3] ? 2 : int'(lcg[20:14]);
            lcg = nxt(lcg);
            pool[6] = lcg; pool[7] = {16'h0000, lcg[15:0]};
            if (lcg[28:26] == 3'd0)
                do_idle(lcg[5], la, lcg[12] ? pool[lcg[2:0]] : 32'd0);
            else
                do_issue(w, lcg[25:23] == 3'd0, la, pool[lcg[2:0]], "");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule